// File: doc/BRIEF.md
# Flash ADC thermometer-to-binary encoder

This block turns the word sampled from a bank of 2^B−1 latched comparators into a B-bit binary code. Comparator line Tk is high when the analog input sits above the k-th reference level, so a clean sample is a run of ones that starts at T1. The encoder first maps that word onto a Gray code in which every comparator line feeds the logic of exactly one Gray bit. A line that settles late, or a single wrong comparator, can therefore disturb only one Gray position. The Gray word is registered and then decoded to binary, most significant bit first.

The thermometer word is captured on a clock edge when the input strobe is high, and the code appears two edges later with its own valid flag. When the strobe is low the input word is ignored and the output code keeps its last value. The resolution B is a parameter; the default build has three output bits and seven comparator lines.

Top module: `flash_therm_encoder`

## Requirements
- R1: A clock edge with `rst_n` low clears every pipeline register; after it `code` is 0 and `code_valid` is 0, whatever `therm_valid` and `therm` were.
- R2: `code_valid` is high exactly when `therm_valid` was sampled high two edges earlier with `rst_n` high on both of those edges.
- R3: Bit k−1 of `therm` carries line Tk. A clean word with lines T1..Tn set and all others clear produces `code` = n; the all-clear word gives 0 and the all-set word gives 2^B−1.
- R4: For any input pattern, the top bit of `code` equals line T(2^(B−1)), that is `therm[2^(B−1)−1]`, of the word that produced it.
- R5: Gray bit p (p < B−1) is set when some line T((4i+1)·2^p) is set while line T((4i+3)·2^p) is clear; the top Gray bit is T(2^(B−1)). For B=3: top = T4, middle = T2 AND NOT T6, low = (T1 AND NOT T3) OR (T5 AND NOT T7). The code is the Gray word decoded from the top bit down, each binary bit being the XOR of the binary bit above it and the Gray bit at its own position. This holds for any input, including words with a wrong line.
- R6: When a clean word with n ones has a single line Tk inverted, the Gray form of `code` (code XOR code>>1) differs from the Gray form of n at most in bit position z, where z is the number of trailing zeros of k.
- R7: While `therm_valid` is low, `therm` has no effect: `code` keeps the value it had and `code_valid` is low two edges later.
- R8: Words presented on consecutive edges each give their own code on consecutive edges, in the same order, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| therm_valid | input | 1 | High when `therm` holds a comparator sample to encode |
| therm | input | 2^B−1 | Comparator lines; bit k−1 is line Tk |
| code | output | B | Binary code, register-fed through the Gray decoder |
| code_valid | output | 1 | High when `code` carries a new result |

## Verification
The situation hardest to reach from the ports is a corrupted comparator word whose wrong line sits at a specific place relative to the end of the run: inside it, just above it, or on the single line that alone sets the top Gray bit. The stimulus sweeps every run length against every single inverted line, so each Gray position is hit by a fault both inside and outside the run. Idle cycles with random-looking words are mixed into that sweep, and one reset lands while results are still in flight, to show that held and dropped results behave as stated.

// File: rtl/flashenc_pkg.sv
// Package: shared size helpers for the flash thermometer encoder.
// Assumes the resolution is at least one bit.
package flashenc_pkg;

    // Number of comparator lines for a given output resolution.
    function automatic int unsigned line_count(input int unsigned bits);
        return (1 << bits) - 1;
    endfunction

    // Number of set/clear line pairs feeding Gray bit pos (pos below the top).
    function automatic int unsigned pair_count(input int unsigned bits, input int unsigned pos);
        return 1 << (bits - 2 - pos);
    endfunction

endpackage

// File: rtl/fe_stage_reg.sv
// Module: fe_stage_reg
// A load-enabled pipeline register with synchronous active-low clear.
// Assumes load and d are stable around the rising edge of clk.
module fe_stage_reg #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture d when load is high; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/fe_therm_to_gray.sv
// Module: fe_therm_to_gray
// Combinational map from comparator lines to a Gray word. Each line is
// used by exactly one Gray bit: line Tk feeds the bit whose index is the
// number of trailing zeros of k. Bit p below the top is the OR of
// "T((4i+1)*2^p) set and T((4i+3)*2^p) clear"; the top bit is T(2^(BITS-1)).
// Assumes BITS >= 1; therm bit k-1 holds line Tk.
module fe_therm_to_gray
    import flashenc_pkg::*;
#(
    parameter  int unsigned BITS  = 3,
    localparam int unsigned LINES = line_count(BITS)
) (
    input  logic [LINES-1:0] therm,
    output logic [BITS-1:0]  gray
);

    for (genvar p = 0; p < BITS; p++) begin : g_bit
        if (p == BITS - 1) begin : g_top
            // Top Gray bit: the single line at the middle of the ladder.
            assign gray[p] = therm[(1 << p) - 1];
        end else begin : g_pairs
            localparam int unsigned PAIRS = pair_count(BITS, p);
            logic [PAIRS-1:0] run_end;
            for (genvar i = 0; i < PAIRS; i++) begin : g_pair
                localparam int unsigned LO = ((4 * i) + 1) << p;
                localparam int unsigned HI = ((4 * i) + 3) << p;
                // One window of the run: lower line set, upper line clear.
                assign run_end[i] = therm[LO-1] & ~therm[HI-1];
            end
            // Gray bit set if any window matches.
            assign gray[p] = |run_end;
        end
    end

endmodule

// File: rtl/fe_gray_to_binary.sv
// Module: fe_gray_to_binary
// Combinational Gray-to-binary decode, top bit first: each binary bit is
// the XOR of all Gray bits at and above its position.
// Assumes BITS >= 1.
module fe_gray_to_binary #(
    parameter int unsigned BITS = 3
) (
    input  logic [BITS-1:0] gray,
    output logic [BITS-1:0] bin
);

    for (genvar p = 0; p < BITS; p++) begin : g_bit
        // Prefix XOR from the top bit down to position p.
        assign bin[p] = ^gray[BITS-1:p];
    end

endmodule

// File: rtl/flash_therm_encoder.sv
// Module: flash_therm_encoder (top)
// Two-stage encoder for a flash converter: stage one captures the
// comparator word on a valid strobe, stage two registers its Gray form,
// and the output is the binary decode of that registered Gray word.
// Latency is two edges; the valid flag follows the same pipe.
// Assumes a synchronous active-low reset held for at least one edge.
module flash_therm_encoder
    import flashenc_pkg::*;
#(
    parameter  int unsigned BITS  = 3,
    localparam int unsigned LINES = line_count(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             therm_valid,
    input  logic [LINES-1:0] therm,
    output logic [BITS-1:0]  code,
    output logic             code_valid
);

    logic [LINES-1:0] cap_therm;
    logic             cap_valid;
    logic [BITS-1:0]  gray_next;
    logic [BITS-1:0]  gray_q;
    logic             out_valid_q;

    // Stage one: hold the comparator word sampled with the strobe.
    fe_stage_reg #(.WIDTH(LINES)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (therm_valid),
        .d     (therm),
        .q     (cap_therm)
    );

    // Line-to-Gray map, one line per Gray bit.
    fe_therm_to_gray #(.BITS(BITS)) u_enc (
        .therm (cap_therm),
        .gray  (gray_next)
    );

    // Stage two: register the Gray word only when stage one is new.
    fe_stage_reg #(.WIDTH(BITS)) u_gray (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_valid),
        .d     (gray_next),
        .q     (gray_q)
    );

    // Binary decode of the registered Gray word.
    fe_gray_to_binary #(.BITS(BITS)) u_dec (
        .gray (gray_q),
        .bin  (code)
    );

    // Valid pipe matching the two data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid   <= 1'b0;
            out_valid_q <= 1'b0;
        end else begin
            cap_valid   <= therm_valid;
            out_valid_q <= cap_valid;
        end
    end

    assign code_valid = out_valid_q;

endmodule

// File: rtl/fe_checker.sv
// Module: fe_checker
// Property checks for flash_therm_encoder, attached by bind. Watches the
// captured comparator word against the final code.
module fe_checker
    import flashenc_pkg::*;
#(
    parameter  int unsigned BITS  = 3,
    localparam int unsigned LINES = line_count(BITS),
    localparam int unsigned TOP   = (1 << (BITS - 1)) - 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             therm_valid,
    input logic [BITS-1:0]  code,
    input logic             code_valid,
    input logic             stage_valid,
    input logic [LINES-1:0] stage_therm
);

    logic [BITS-1:0] stage_ones;
    logic            stage_clean;

    // Count of set lines and whether they form a clean run from T1.
    always_comb begin
        stage_ones  = BITS'($countones(stage_therm));
        stage_clean = ((stage_therm & (stage_therm + 1'b1)) == '0);
    end

    AST_VALID_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(therm_valid, 2)); // R2

    AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(therm_valid, 2) && $past(rst_n) && $past(rst_n, 2)) |-> code_valid); // R2

    AST_CLEAN_RUN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_valid && stage_clean) |=> (code == $past(stage_ones))); // R3

    AST_TOP_BIT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_valid |=> (code[BITS-1] == $past(stage_therm[TOP]))); // R4

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !code_valid) |-> $stable(code)); // R7

endmodule

bind flash_therm_encoder fe_checker #(.BITS(BITS)) u_fe_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .therm_valid (therm_valid),
    .code        (code),
    .code_valid  (code_valid),
    .stage_valid (cap_valid),
    .stage_therm (cap_therm)
);

// File: tb/test_flash_therm_encoder.sv
`timescale 1ns/1ps
module test_flash_therm_encoder;

    localparam int B = 3;
    localparam int N = (1 << B) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         therm_valid = 1'b0;
    logic [N-1:0] therm = '0;
    logic [B-1:0] code;
    logic         code_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit started  = 1'b0;

    // Reference pipeline state.
    bit           m_v1, m_v2, m_rst_last;
    int           m_c1, m_code, m_n1, m_n2, m_k1, m_k2;
    logic [N-1:0] m_t1, m_t2;
    string        m_tag1, m_tag2;

    flash_therm_encoder #(.BITS(B)) i_flash_therm_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .therm_valid (therm_valid),
        .therm       (therm),
        .code        (code),
        .code_valid  (code_valid)
    );

    always #10 clk = ~clk;

    function automatic int tz(input int v);
        int c = 0;
        while (((v >> c) & 1) == 0 && c < 31) c++;
        return c;
    endfunction

    // Line-pair rule of R5 followed by top-down Gray decode.
    function automatic int rule_code(input logic [N-1:0] t);
        int gv = 0;
        int bv = 0;
        int acc = 0;
        for (int k = 1; k <= N; k++) begin
            int p = tz(k);
            int up = k + (2 << p);
            if (((k >> p) % 4) == 1) begin
                bit upper_set = (up <= N) ? t[up-1] : 1'b0;
                if (t[k-1] && !upper_set) gv |= (1 << p);
            end
        end
        for (int i = B - 1; i >= 0; i--) begin
            acc ^= (gv >> i) & 1;
            bv |= acc << i;
        end
        return bv;
    endfunction

    function automatic logic [N-1:0] run_of(input int n);
        return N'((1 << n) - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Compare outputs against the model, then drive the next inputs.
    task automatic step(input bit rst, input bit v, input logic [N-1:0] t,
                        input int n, input int k, input string tag);
        @(negedge clk);
        if (started) begin
            check(code_valid == m_v2, "R2", int'(code_valid), int'(m_v2));
            if (m_v2) begin
                check(int'(code) == m_code, m_tag2, int'(code), m_code);
                check(code[B-1] == m_t2[(1 << (B - 1)) - 1], "R4",
                      int'(code[B-1]), int'(m_t2[(1 << (B - 1)) - 1]));
                if (m_k2 != 0) begin
                    int go = int'(code) ^ (int'(code) >> 1);
                    int gn = m_n2 ^ (m_n2 >> 1);
                    check(((go ^ gn) & ~(1 << tz(m_k2))) == 0, "R6", go, gn);
                end
            end else begin
                check(int'(code) == m_code, m_rst_last ? "R1" : "R7", int'(code), m_code);
            end
        end
        started = 1'b1;
        rst_n = ~rst;
        therm_valid = v;
        therm = t;
        if (rst) begin
            m_v1 = 0; m_v2 = 0; m_code = 0; m_c1 = 0; m_t1 = '0; m_t2 = '0;
            m_rst_last = 1;
        end else begin
            m_rst_last = 0;
            if (m_v1) begin
                m_code = m_c1; m_n2 = m_n1; m_k2 = m_k1; m_t2 = m_t1; m_tag2 = m_tag1;
            end
            m_v2 = m_v1;
            if (v) begin
                m_t1 = t; m_n1 = n; m_k1 = k; m_tag1 = tag;
                m_c1 = (k == 0) ? n : rule_code(t);
            end
            m_v1 = v;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset with a live strobe and all lines set.
        for (int i = 0; i < 3; i++) step(1, 1, '1, 0, 0, "R1");
        step(0, 0, '0, 0, 0, "R1");
        // R3 and R8: every clean run on consecutive edges.
        for (int n = 0; n <= N; n++) step(0, 1, run_of(n), n, 0, "R8");
        for (int n = N; n >= 0; n--) step(0, 1, run_of(n), n, 0, "R3");
        // R7: idle cycles with junk words must not disturb the held code.
        for (int i = 0; i < 4; i++) step(0, 0, N'(7'h2A ^ i), 0, 0, "R7");
        step(0, 1, run_of(5), 5, 0, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, N'(7'h55 + i), 0, 0, "R7");
        // R5 and R6: every run length against every single inverted line.
        for (int n = 0; n <= N; n++) begin
            for (int k = 1; k <= N; k++) begin
                step(0, 1, run_of(n) ^ N'(1 << (k - 1)), n, k, "R5");
                if (k == 4) step(0, 0, N'(7'h33), 0, 0, "R7");
            end
        end
        // R1: reset lands while results are in flight.
        step(0, 1, run_of(6), 6, 0, "R3");
        step(0, 1, run_of(2), 2, 0, "R3");
        step(1, 1, run_of(7), 7, 0, "R1");
        step(0, 0, '0, 0, 0, "R1");
        step(0, 1, run_of(1), 1, 0, "R3");
        for (int i = 0; i < 4; i++) step(0, 0, '1, 0, 0, "R7");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule